// File: doc/BRIEF.md
# 4x4 Sum-of-Absolute-Differences Processing Element

This block scores candidate reference blocks against one 4x4 current block during motion search. The current block is written once per search as four 32-bit row words. Each row word carries four 8-bit pixels. Each candidate is then written the same way on the reference port, together with its signed displacement.

Every pixel position has its own current register, reference register and subtractor. All sixteen absolute differences therefore form in the same cycle. A registered two-level adder tree reduces them: four 10-bit row sums, then one 12-bit total. A comparator keeps the smallest total seen since the last search start, along with the displacement that produced it.

A search controller pulses `start_i` and loads the current block. It then streams candidates and reads the best score and vector once the last candidate's `done_o` pulse has appeared.

Top module: `sad4x4_pe`

## Requirements
- R1: While reset is asserted and right after it, `min_sad_o` is 4095 (all ones), both vector outputs are 0 and `done_o` is 0.
- R2: A write places byte k of the data word (bits 8k+7 down to 8k) in column k of the row given by the 2-bit row index. The score of a candidate is the sum, over all 16 positions, of the absolute difference between current and reference pixel.
- R3: The absolute difference never wraps, whichever operand is larger. All-255 against all-0 scores 4080 in both directions.
- R4: A reference write to row 3 starts an evaluation. `done_o` is high for exactly the one cycle following the second rising edge after that write, and the result is visible on `min_sad_o` in that same cycle. Writes to rows 0 to 2 never raise `done_o`.
- R5: A candidate whose score is strictly below the stored minimum replaces the minimum and the stored vector. A higher score changes neither.
- R6: A candidate whose score equals the stored minimum leaves the stored minimum and the earlier vector in place.
- R7: `start_i` on its own sets `min_sad_o` to 4095 and the vector outputs to 0.
- R8: When `start_i` falls on the cycle in which an evaluation completes, that candidate becomes the first result of the new search. Its score and vector are stored even if they are worse than the old minimum.
- R9: The vector stored with a candidate is the one present on `mv_x_i`/`mv_y_i` during its row-3 reference write. Values present during the row 0 to 2 writes are ignored.
- R10: The current block stays in place across candidates, so reloading only the reference rows is enough to score a new candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new search (reset the running minimum) |
| cur_we_i | input | 1 | Current-block row write enable |
| cur_row_i | input | 2 | Current-block row index |
| cur_data_i | input | 32 | Current-block row, four 8-bit pixels |
| ref_we_i | input | 1 | Reference row write enable |
| ref_row_i | input | 2 | Reference row index; row 3 triggers evaluation |
| ref_data_i | input | 32 | Reference row, four 8-bit pixels |
| mv_x_i | input | 8 | Signed horizontal displacement of the candidate |
| mv_y_i | input | 8 | Signed vertical displacement of the candidate |
| min_sad_o | output | 12 | Smallest score since search start |
| best_mv_x_o | output | 8 | Horizontal displacement of the best candidate |
| best_mv_y_o | output | 8 | Vertical displacement of the best candidate |
| done_o | output | 1 | One-cycle pulse when an evaluation completes |

## Verification
A search restart and the completion of a candidate evaluation can reach the minimum register in the same cycle. The bench provokes this by leaving a minimum of 16 in place and then writing the last row of a candidate scoring 48. It raises `start_i` exactly two edges after that row-3 write. It then expects 48 and the new candidate's vector, not 4095 and not the old 16. Separately, the checks confirm that a start with no evaluation in flight clears the minimum to 4095 with zero vectors.

// File: rtl/sad_pkg.sv
package sad_pkg;
  parameter int unsigned PIX_W_DEF = 8;
  parameter int unsigned DIM_DEF   = 4;
  parameter int unsigned MV_W      = 8;

  typedef struct packed {
    logic signed [MV_W-1:0] x;
    logic signed [MV_W-1:0] y;
  } mv_t;
endpackage

// File: rtl/sad_block_regs.sv
module sad_block_regs #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned DIM   = 4,
  localparam int unsigned RW   = $clog2(DIM),
  localparam int unsigned ROW_W = DIM * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RW-1:0]    row_i,
  input  logic [ROW_W-1:0] data_i,
  output logic [PIX_W-1:0] pix_o [DIM][DIM]
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pix_o[r][c] <= '0;
        else if (we_i && row_i == RW'(r)) pix_o[r][c] <= data_i[c*PIX_W +: PIX_W];
      end
    end
  end
endmodule

// File: rtl/sad_row_sum.sv
module sad_row_sum #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned DIM   = 4,
  localparam int unsigned OUT_W = PIX_W + $clog2(DIM)
) (
  input  logic [PIX_W-1:0] cur_i [DIM],
  input  logic [PIX_W-1:0] ref_i [DIM],
  output logic [OUT_W-1:0] sum_o
);
  logic [PIX_W-1:0] ad [DIM];

  // larger minus smaller: no wrap
  for (genvar c = 0; c < DIM; c++) begin : g_ad
    assign ad[c] = (cur_i[c] >= ref_i[c]) ? cur_i[c] - ref_i[c] : ref_i[c] - cur_i[c];
  end

  always_comb begin
    sum_o = '0;
    for (int c = 0; c < DIM; c++) sum_o = sum_o + OUT_W'(ad[c]);
  end
endmodule

// File: rtl/sad_min_track.sv
module sad_min_track #(
  parameter int unsigned SAD_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [SAD_W-1:0] sad_i,
  input  sad_pkg::mv_t     mv_i,
  output logic [SAD_W-1:0] min_o,
  output sad_pkg::mv_t     mv_o,
  output logic             done_o
);
  // strict compare: ties keep the earlier candidate
  logic better;
  assign better = valid_i && (start_i || sad_i < min_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_o  <= '1;
      mv_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (better) begin
        min_o <= sad_i;
        mv_o  <= mv_i;
      end else if (start_i) begin
        min_o <= '1;
        mv_o  <= '0;
      end
    end
  end
endmodule

// File: rtl/sad4x4_pe.sv
module sad4x4_pe #(
  parameter int unsigned PIX_W = sad_pkg::PIX_W_DEF,
  parameter int unsigned DIM   = sad_pkg::DIM_DEF,
  localparam int unsigned RW     = $clog2(DIM),
  localparam int unsigned ROW_W  = DIM * PIX_W,
  localparam int unsigned RSUM_W = PIX_W + $clog2(DIM),
  localparam int unsigned SAD_W  = RSUM_W + $clog2(DIM),
  localparam int unsigned MV_W   = sad_pkg::MV_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   cur_we_i,
  input  logic [RW-1:0]          cur_row_i,
  input  logic [ROW_W-1:0]       cur_data_i,
  input  logic                   ref_we_i,
  input  logic [RW-1:0]          ref_row_i,
  input  logic [ROW_W-1:0]       ref_data_i,
  input  logic signed [MV_W-1:0] mv_x_i,
  input  logic signed [MV_W-1:0] mv_y_i,
  output logic [SAD_W-1:0]       min_sad_o,
  output logic signed [MV_W-1:0] best_mv_x_o,
  output logic signed [MV_W-1:0] best_mv_y_o,
  output logic                   done_o
);
  logic [PIX_W-1:0]  cur_pix [DIM][DIM];
  logic [PIX_W-1:0]  ref_pix [DIM][DIM];
  logic [RSUM_W-1:0] rsum    [DIM];
  logic [RSUM_W-1:0] rsum_q  [DIM];
  logic [SAD_W-1:0]  sad;
  logic              trig, v1_q, v2_q;
  sad_pkg::mv_t      mv1_q, mv2_q, best_mv;

  sad_block_regs #(.PIX_W(PIX_W), .DIM(DIM)) u_cur (
    .clk_i, .rst_ni, .we_i(cur_we_i), .row_i(cur_row_i), .data_i(cur_data_i), .pix_o(cur_pix)
  );
  sad_block_regs #(.PIX_W(PIX_W), .DIM(DIM)) u_ref (
    .clk_i, .rst_ni, .we_i(ref_we_i), .row_i(ref_row_i), .data_i(ref_data_i), .pix_o(ref_pix)
  );

  for (genvar r = 0; r < DIM; r++) begin : g_rsum
    sad_row_sum #(.PIX_W(PIX_W), .DIM(DIM)) u_row (
      .cur_i(cur_pix[r]), .ref_i(ref_pix[r]), .sum_o(rsum[r])
    );
  end

  assign trig = ref_we_i && ref_row_i == RW'(DIM - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      mv1_q <= '0;
      mv2_q <= '0;
      for (int r = 0; r < DIM; r++) rsum_q[r] <= '0;
    end else begin
      v1_q <= trig;
      v2_q <= v1_q;
      if (trig) mv1_q <= '{x: mv_x_i, y: mv_y_i};
      mv2_q <= mv1_q;
      for (int r = 0; r < DIM; r++) rsum_q[r] <= rsum[r];
    end
  end

  always_comb begin
    sad = '0;
    for (int r = 0; r < DIM; r++) sad = sad + SAD_W'(rsum_q[r]);
  end

  sad_min_track #(.SAD_W(SAD_W)) u_min (
    .clk_i, .rst_ni, .start_i, .valid_i(v2_q), .sad_i(sad), .mv_i(mv2_q),
    .min_o(min_sad_o), .mv_o(best_mv), .done_o
  );

  assign best_mv_x_o = best_mv.x;
  assign best_mv_y_o = best_mv.y;
endmodule

// File: rtl/sad4x4_pe_chk.sv
module sad4x4_pe_chk #(
  parameter int unsigned DIM   = 4,
  parameter int unsigned SAD_W = 12,
  parameter int unsigned MV_W  = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     ref_we_i,
  input logic [$clog2(DIM)-1:0]   ref_row_i,
  input logic [SAD_W-1:0]         min_sad_o,
  input logic signed [MV_W-1:0]   best_mv_x_o,
  input logic signed [MV_W-1:0]   best_mv_y_o,
  input logic                     done_o
);
  logic t1, t2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1 <= 1'b0;
      t2 <= 1'b0;
    end else begin
      t1 <= ref_we_i && ref_row_i == $clog2(DIM)'(DIM - 1);
      t2 <= t1;
    end
  end

  assert_done_after_two_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t2 |=> done_o);
  assert_no_stray_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t2 |=> !done_o);
  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !t2) |=> ($stable(min_sad_o) && $stable(best_mv_x_o) && $stable(best_mv_y_o)));
  assert_never_rises_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> min_sad_o <= $past(min_sad_o));
  assert_start_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !t2) |=> (min_sad_o == '1 && best_mv_x_o == '0 && best_mv_y_o == '0));
  assert_start_keeps_cand_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && t2) |=> min_sad_o != '1);
endmodule

bind sad4x4_pe sad4x4_pe_chk #(.DIM(DIM), .SAD_W(SAD_W), .MV_W(MV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ref_we_i(ref_we_i),
  .ref_row_i(ref_row_i), .min_sad_o(min_sad_o), .best_mv_x_o(best_mv_x_o),
  .best_mv_y_o(best_mv_y_o), .done_o(done_o)
);

// File: tb/sad4x4_pe_test.sv
module sad4x4_pe_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              cur_we = 1'b0, ref_we = 1'b0;
  logic [1:0]        cur_row = '0, ref_row = '0;
  logic [31:0]       cur_data = '0, ref_data = '0;
  logic signed [7:0] mv_x = '0, mv_y = '0;
  logic [11:0]       min_sad;
  logic signed [7:0] bx, by;
  logic              done;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  sad4x4_pe uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cur_we_i(cur_we), .cur_row_i(cur_row), .cur_data_i(cur_data),
    .ref_we_i(ref_we), .ref_row_i(ref_row), .ref_data_i(ref_data),
    .mv_x_i(mv_x), .mv_y_i(mv_y),
    .min_sad_o(min_sad), .best_mv_x_o(bx), .best_mv_y_o(by), .done_o(done)
  );

  // {cur rows 3..0, ref rows 3..0, expected score}
  localparam int NV = 8;
  localparam logic [267:0] VEC [NV] = '{
    {{4{32'h00000000}}, {4{32'h00000000}}, 12'd0},
    {{4{32'h10101010}}, {4{32'h13131313}}, 12'd48},
    {{4{32'hFFFFFFFF}}, {4{32'h00000000}}, 12'd4080},
    {{4{32'h00000000}}, {4{32'hFFFFFFFF}}, 12'd4080},
    {{4{32'h04030201}}, {4{32'h01020304}}, 12'd32},
    {{4{32'h80808080}}, {4{32'h7F81807F}}, 12'd12},
    {{4{32'h00000000}}, {32'h0, 32'h00000500, 32'h0, 32'h0}, 12'd5},
    {{32'h0, 32'h0, 32'h00000009, 32'h0}, {32'h0, 32'h0, 32'h00000900, 32'h0}, 12'd18}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic load_cur(input logic [127:0] blk);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      cur_we = 1'b1; cur_row = 2'(r); cur_data = blk[32*r +: 32];
    end
    @(negedge clk) cur_we = 1'b0;
  endtask

  // rows 0..2 carry a decoy vector (R9); row 3 carries the real one
  task automatic write_ref_rows(input logic [127:0] blk, input int last, input int mx, input int my);
    for (int r = 0; r <= last; r++) begin
      @(negedge clk);
      ref_we = 1'b1; ref_row = 2'(r); ref_data = blk[32*r +: 32];
      mv_x = (r == 3) ? 8'(mx) : 8'sd55;
      mv_y = (r == 3) ? 8'(my) : -8'sd55;
    end
    @(negedge clk) ref_we = 1'b0;
  endtask

  // returns at the negedge after the second edge following the row-3 write
  task automatic wait_done(input string req);
    @(negedge clk) chk({req, " R4 done early"}, int'(done), 0);
    @(negedge clk) chk({req, " R4 done pulse"}, int'(done), 1);
  endtask

  task automatic eval(input logic [127:0] blk, input int mx, input int my);
    write_ref_rows(blk, 3, mx, my);
    wait_done("eval");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 min in reset", int'(min_sad), 4095);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 min", int'(min_sad), 4095);
    chk("R1 mv x", int'(bx), 0);
    chk("R1 mv y", int'(by), 0);
    chk("R1 done", int'(done), 0);

    // table walk: R2 R3 R9, one search per vector
    for (int i = 0; i < NV; i++) begin
      do_start();
      load_cur(VEC[i][267:140]);
      write_ref_rows(VEC[i][139:12], 3, i + 1, -(i + 1));
      wait_done("R2 vec");
      chk("R2/R3 score", int'(min_sad), int'(VEC[i][11:0]));
      chk("R9 mv x", int'(bx), i + 1);
      chk("R9 mv y", int'(by), -(i + 1));
      @(negedge clk) chk("R4 done one cycle", int'(done), 0);
    end

    // R7 then R4: partial reference writes do not evaluate
    do_start();
    chk("R7 min cleared", int'(min_sad), 4095);
    chk("R7 mv x cleared", int'(bx), 0);
    chk("R7 mv y cleared", int'(by), 0);
    load_cur({4{32'h0}});
    write_ref_rows({4{32'h02020202}}, 2, 9, 9);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) chk("R4 no done for rows 0-2", int'(done), 0);
    end
    chk("R4 min untouched by rows 0-2", int'(min_sad), 4095);

    // R5 R6 R10 sequence with the current block kept
    eval({4{32'h02020202}}, 1, -1);
    chk("R10 first score", int'(min_sad), 32);
    chk("R5 mv x", int'(bx), 1);
    eval({4{32'h03030303}}, 2, 2);
    chk("R5 worse keeps min", int'(min_sad), 32);
    chk("R5 worse keeps mv", int'(bx), 1);
    eval({4{32'h02020202}}, 3, 3);
    chk("R6 tie keeps min", int'(min_sad), 32);
    chk("R6 tie keeps mv x", int'(bx), 1);
    chk("R6 tie keeps mv y", int'(by), -1);
    eval({4{32'h01010101}}, -4, 5);
    chk("R5 better min", int'(min_sad), 16);
    chk("R5 better mv x", int'(bx), -4);
    chk("R5 better mv y", int'(by), 5);

    // R8: start on the completion cycle of a worse candidate
    write_ref_rows({4{32'h03030303}}, 3, 6, -7);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8 done on collision", int'(done), 1);
    chk("R8 min is candidate", int'(min_sad), 48);
    chk("R8 mv x", int'(bx), 6);
    chk("R8 mv y", int'(by), -7);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule